// File: doc/BRIEF.md
# Sub-page write permission gate

This block rules on each guest memory request after the page-level translation has produced the leaf entry that maps a 4KB page. For most requests it settles the outcome at once. A read is always passed. A write is allowed when the leaf's page write bit is set. A write is denied when the sub-page path is off for that page.

When a write hits a page that is write-protected at page level but marked for fine-grained control, the gate passes the guest-physical address to an external table-walk engine. It stays busy until the 64-bit permission word comes back. It then picks the permission bit that belongs to the 128-byte slice being written and turns it into a verdict. If the walk reports a miss or a misconfiguration, the gate returns a walk-fault verdict. That verdict carries an exit qualification word and an exit reason code.

Only one lookup is in flight at a time. The request interface is a valid/ready pair. Each verdict is a single-cycle registered pulse, with its qualification and reason valid in the same cycle.

Top module: `spw_gate`

## Requirements
- R1: During and right after reset, `req_ready` is 1 and `res_valid` and `walk_req_valid` are 0. A reset in the middle of a lookup abandons that lookup.
- R2: The sub-page path is taken only for a write whose `req_spp_en` is 1, whose leaf bit 1 is 0 and whose leaf bit 61 is 1. Every other accepted request gives `res_valid` one cycle after acceptance and raises no walk.
- R3: An accepted write whose leaf bit 1 is 1 yields verdict 0 (allow), whatever leaf bit 61 and `req_spp_en` hold.
- R4: An accepted write whose leaf bit 1 is 0 yields verdict 1 (violation) when leaf bit 61 is 0 or `req_spp_en` is 0.
- R5: A request that takes the sub-page path raises `walk_req_valid` for exactly one cycle, one cycle after acceptance, with `walk_req_gpa` equal to the accepted address.
- R6: On a walk response with status 0 (ok), the sub-page index i is address bits 11:7 of the accepted request. Permission-word bit 2i set gives verdict 0, and clear gives verdict 1. Odd bits of the word have no effect. The verdict appears one cycle after the response.
- R7: On a walk response with status 1 (miss), the verdict is 2 (walk fault) and `res_qual` has only bit 11 set. With status 2 or 3 (misconfiguration), the verdict is 2 and `res_qual` is zero.
- R8: `res_reason` is 66 whenever the verdict is 2 and is 0 for every other result.
- R9: An accepted read (`req_write` = 0) yields verdict 0 and never raises a walk.
- R10: `req_ready` is 0 from the cycle after a lookup is accepted until the cycle after its response. Requests presented while it is 0 produce no result. A walk response arriving while no lookup is pending produces no result.
- R11: Verdict code 3 is never produced. `res_verdict`, `res_qual` and `res_reason` are all zero whenever `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Gate can accept a request (no lookup pending) |
| req_spp_en | input | 1 | Global sub-page control for this request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_leaf | input | 64 | Leaf translation entry mapping the 4KB page |
| req_gpa | input | GPA_W | Guest-physical address of the access |
| walk_req_valid | output | 1 | One-cycle lookup start to the walk engine |
| walk_req_gpa | output | GPA_W | Address to look up |
| walk_rsp_valid | input | 1 | Walk engine response strobe |
| walk_rsp_status | input | 2 | 0 ok, 1 miss, 2 or 3 misconfiguration |
| walk_rsp_perm | input | 64 | Returned permission word (valid with status 0) |
| res_valid | output | 1 | Verdict strobe |
| res_verdict | output | 2 | 0 allow, 1 violation, 2 walk fault |
| res_qual | output | 64 | Exit qualification for walk faults |
| res_reason | output | 16 | Exit reason code, 66 on walk faults |

## Verification
The assertions assume that the walk engine answers only after it has seen `walk_req_valid`, and that it answers once per lookup. They also assume that the request inputs are stable whenever `req_valid` is high in a cycle with `req_ready` high. The bench changes request and response inputs only on the falling clock edge. It raises `walk_rsp_valid` only after sampling the walk start, and holds it for one cycle. It sends stray responses only in idle windows, where the requirements say they must be dropped. Requests offered while the gate is busy are pulsed for exactly the busy cycles, so none is taken up later.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam int LEAF_WR_BIT   = 1;
  localparam int LEAF_SUB_BIT  = 61;
  localparam int QUAL_MISS_BIT = 11;
  localparam logic [15:0] FAULT_REASON = 16'd66;

  typedef enum logic [1:0] {
    V_ALLOW = 2'd0,
    V_DENY  = 2'd1,
    V_FAULT = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    P_ALLOW = 2'd0,
    P_DENY  = 2'd1,
    P_WALK  = 2'd2
  } path_e;

  typedef enum logic [1:0] {
    S_OK       = 2'd0,
    S_MISS     = 2'd1,
    S_BADENTRY = 2'd2
  } wstat_e;

  // Route a request given the global control, the two leaf bits and the kind.
  function automatic path_e route(input logic en, input logic wr_bit,
                                  input logic sub_bit, input logic is_write);
    if (!is_write)          return P_ALLOW;
    if (wr_bit)             return P_ALLOW;
    if (en && sub_bit)      return P_WALK;
    return P_DENY;
  endfunction

  // Qualification word for a walk fault.
  function automatic logic [63:0] fault_qual(input logic miss);
    logic [63:0] q;
    q = '0;
    q[QUAL_MISS_BIT] = miss;
    return q;
  endfunction
endpackage

// File: rtl/spw_classify.sv
module spw_classify
  import spw_pkg::*;
(
  input  logic  en,
  input  logic  wr_bit,
  input  logic  sub_bit,
  input  logic  is_write,
  output path_e path
);
  assign path = route(en, wr_bit, sub_bit, is_write);
endmodule

// File: rtl/spw_perm_pick.sv
module spw_perm_pick #(
  parameter int IDX_W = 5,
  localparam int NUM_SUB = 1 << IDX_W,
  localparam int PERM_W  = 2 * NUM_SUB
) (
  input  logic [PERM_W-1:0] perm,
  input  logic [IDX_W-1:0]  idx,
  output logic              allow
);
  logic [NUM_SUB-1:0] even_bits;
  logic [NUM_SUB-1:0] odd_unused;

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_slice
    assign even_bits[i]  = perm[2*i];
    assign odd_unused[i] = perm[2*i+1];
  end

  logic perm_unused;
  assign perm_unused = ^odd_unused;
  assign allow = even_bits[idx];
endmodule

// File: rtl/spw_fault_qual.sv
module spw_fault_qual
  import spw_pkg::*;
(
  input  logic [1:0]  status,
  output logic        is_fault,
  output logic [63:0] qual,
  output logic [15:0] reason
);
  logic miss;
  assign miss     = (status == S_MISS);
  assign is_fault = (status != S_OK);
  assign qual     = is_fault ? fault_qual(miss) : 64'd0;
  assign reason   = is_fault ? FAULT_REASON : 16'd0;
endmodule

// File: rtl/spw_gate.sv
module spw_gate
  import spw_pkg::*;
#(
  parameter int GPA_W   = 52,
  parameter int SUB_LG  = 7,
  parameter int PAGE_LG = 12,
  localparam int IDX_W  = PAGE_LG - SUB_LG,
  localparam int PERM_W = 2 * (1 << IDX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_spp_en,
  input  logic              req_write,
  input  logic [63:0]       req_leaf,
  input  logic [GPA_W-1:0]  req_gpa,
  output logic              walk_req_valid,
  output logic [GPA_W-1:0]  walk_req_gpa,
  input  logic              walk_rsp_valid,
  input  logic [1:0]        walk_rsp_status,
  input  logic [PERM_W-1:0] walk_rsp_perm,
  output logic              res_valid,
  output logic [1:0]        res_verdict,
  output logic [63:0]       res_qual,
  output logic [15:0]       res_reason
);
  // Named internal events
  logic       busy_q;
  logic       req_fire;
  logic       fast_done;
  logic       walk_start;
  logic       walk_done;
  path_e      path;
  logic [IDX_W-1:0] idx_q;
  logic       slice_allow;
  logic       rsp_fault;
  logic [63:0] rsp_qual;
  logic [15:0] rsp_reason;

  logic leaf_unused;
  assign leaf_unused = ^{req_leaf[63:LEAF_SUB_BIT+1], req_leaf[LEAF_SUB_BIT-1:LEAF_WR_BIT+1],
                         req_leaf[0]};

  spw_classify u_classify (
    .en       (req_spp_en),
    .wr_bit   (req_leaf[LEAF_WR_BIT]),
    .sub_bit  (req_leaf[LEAF_SUB_BIT]),
    .is_write (req_write),
    .path     (path)
  );

  spw_perm_pick #(.IDX_W(IDX_W)) u_pick (
    .perm  (walk_rsp_perm),
    .idx   (idx_q),
    .allow (slice_allow)
  );

  spw_fault_qual u_fq (
    .status   (walk_rsp_status),
    .is_fault (rsp_fault),
    .qual     (rsp_qual),
    .reason   (rsp_reason)
  );

  assign req_ready  = !busy_q;
  assign req_fire   = req_valid && req_ready;
  assign walk_start = req_fire && (path == P_WALK);
  assign fast_done  = req_fire && (path != P_WALK);
  assign walk_done  = busy_q && walk_rsp_valid;

  // Next result
  logic        nx_valid;
  logic [1:0]  nx_verdict;
  logic [63:0] nx_qual;
  logic [15:0] nx_reason;

  always_comb begin
    nx_valid   = 1'b0;
    nx_verdict = V_ALLOW;
    nx_qual    = '0;
    nx_reason  = '0;
    if (walk_done) begin
      nx_valid = 1'b1;
      if (rsp_fault) begin
        nx_verdict = V_FAULT;
        nx_qual    = rsp_qual;
        nx_reason  = rsp_reason;
      end else begin
        nx_verdict = slice_allow ? V_ALLOW : V_DENY;
      end
    end else if (fast_done) begin
      nx_valid   = 1'b1;
      nx_verdict = (path == P_ALLOW) ? V_ALLOW : V_DENY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q         <= 1'b0;
      idx_q          <= '0;
      walk_req_valid <= 1'b0;
      walk_req_gpa   <= '0;
      res_valid      <= 1'b0;
      res_verdict    <= V_ALLOW;
      res_qual       <= '0;
      res_reason     <= '0;
    end else begin
      walk_req_valid <= walk_start;
      if (walk_start) begin
        busy_q       <= 1'b1;
        idx_q        <= req_gpa[PAGE_LG-1:SUB_LG];
        walk_req_gpa <= req_gpa;
      end else if (walk_done) begin
        busy_q <= 1'b0;
      end
      res_valid   <= nx_valid;
      res_verdict <= nx_verdict;
      res_qual    <= nx_qual;
      res_reason  <= nx_reason;
    end
  end
endmodule

// File: rtl/spw_gate_checker.sv
module spw_gate_checker #(
  parameter int GPA_W = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_spp_en,
  input logic              req_write,
  input logic [63:0]       req_leaf,
  input logic              walk_req_valid,
  input logic              walk_rsp_valid,
  input logic              res_valid,
  input logic [1:0]        res_verdict,
  input logic [63:0]       res_qual,
  input logic [15:0]       res_reason
);
  logic fire, sub_path;
  assign fire     = req_valid && req_ready;
  assign sub_path = req_write && req_spp_en && !req_leaf[1] && req_leaf[61];

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !sub_path) |=> (res_valid && !walk_req_valid));

  assert_write_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && req_leaf[1]) |=> (res_verdict == 2'd0));

  assert_deny_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && !req_leaf[1] && !(req_spp_en && req_leaf[61])) |=> (res_verdict == 2'd1));

  assert_walk_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sub_path) |=> (walk_req_valid && !res_valid));

  assert_walk_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |=> !walk_req_valid);

  assert_qual_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_qual & ~64'h800) == 64'd0));

  assert_fault_reason_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_verdict == 2'd2) ? (res_reason == 16'd66) : (res_reason == 16'd0)));

  assert_read_allow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write) |=> (res_valid && res_verdict == 2'd0 && !walk_req_valid));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> !req_ready);

  assert_idle_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && walk_rsp_valid && !req_valid) |=> !res_valid);

  assert_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_verdict != 2'd3));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_verdict == 2'd0 && res_qual == 64'd0 && res_reason == 16'd0));
endmodule

bind spw_gate spw_gate_checker #(.GPA_W(GPA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_spp_en     (req_spp_en),
  .req_write      (req_write),
  .req_leaf       (req_leaf),
  .walk_req_valid (walk_req_valid),
  .walk_rsp_valid (walk_rsp_valid),
  .res_valid      (res_valid),
  .res_verdict    (res_verdict),
  .res_qual       (res_qual),
  .res_reason     (res_reason)
);

// File: tb/tb_spw_gate.sv
module tb_spw_gate;
  localparam int GPA_W = 52;
  localparam logic [GPA_W-1:0] PAGE_BASE = 52'hF_EDCB_A987_6000;
  localparam logic [63:0] LEAF_NOISE = 64'h1234_5000_0000_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_spp_en = 1'b0, req_write = 1'b0;
  logic [63:0] req_leaf = '0;
  logic [GPA_W-1:0] req_gpa = '0;
  logic walk_rsp_valid = 1'b0;
  logic [1:0] walk_rsp_status = '0;
  logic [63:0] walk_rsp_perm = '0;
  logic req_ready, walk_req_valid, res_valid;
  logic [GPA_W-1:0] walk_req_gpa;
  logic [1:0] res_verdict;
  logic [63:0] res_qual;
  logic [15:0] res_reason;

  always #2 clk = ~clk;

  spw_gate #(.GPA_W(GPA_W)) dut (.*);

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic w, en, b1, b61;
    logic [4:0] idx;
    logic [1:0] st;
    logic [63:0] perm;
    logic [1:0] ev;
    logic [63:0] eq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,1'b1,5'd3, 2'd0,64'd0,2'd0,64'd0},                  // R3
    '{1'b1,1'b1,1'b0,1'b0,5'd3, 2'd0,64'd0,2'd1,64'd0},                  // R4
    '{1'b1,1'b0,1'b0,1'b1,5'd9, 2'd0,64'd0,2'd1,64'd0},                  // R2 R4 disabled
    '{1'b1,1'b0,1'b1,1'b0,5'd9, 2'd0,64'd0,2'd0,64'd0},                  // R3
    '{1'b0,1'b1,1'b0,1'b1,5'd1, 2'd0,64'd0,2'd0,64'd0},                  // R9 read
    '{1'b1,1'b1,1'b0,1'b1,5'd0, 2'd0,64'd1,2'd0,64'd0},                  // R6 idx 0
    '{1'b1,1'b1,1'b0,1'b1,5'd31,2'd0,64'h4000_0000_0000_0000,2'd0,64'd0},// R6 idx 31
    '{1'b1,1'b1,1'b0,1'b1,5'd31,2'd0,64'hAAAA_AAAA_AAAA_AAAA,2'd1,64'd0},// R6 odd bits
    '{1'b1,1'b1,1'b0,1'b1,5'd5, 2'd0,~(64'd1 << 10),2'd1,64'd0},         // R6 single clear
    '{1'b1,1'b1,1'b0,1'b1,5'd17,2'd0,64'd1 << 34,2'd0,64'd0},            // R6 idx 17
    '{1'b1,1'b1,1'b0,1'b1,5'd8, 2'd1,64'hFFFF_FFFF_FFFF_FFFF,2'd2,64'h800}, // R7 miss
    '{1'b1,1'b1,1'b0,1'b1,5'd8, 2'd2,64'hFFFF_FFFF_FFFF_FFFF,2'd2,64'd0}    // R7 misconfig
  };

  function automatic logic [GPA_W-1:0] mk_gpa(input logic [4:0] idx);
    return PAGE_BASE | GPA_W'({idx, 7'h2B});
  endfunction

  function automatic logic [63:0] mk_leaf(input logic b1, input logic b61);
    logic [63:0] l;
    l = LEAF_NOISE;
    l[1] = b1;
    l[61] = b61;
    return l;
  endfunction

  task automatic drive_req(input vec_t v);
    req_valid  = 1'b1;
    req_write  = v.w;
    req_spp_en = v.en;
    req_leaf   = mk_leaf(v.b1, v.b61);
    req_gpa    = mk_gpa(v.idx);
  endtask

  task automatic run_vec(input vec_t v, input int delay);
    logic walk;
    walk = v.w && v.en && !v.b1 && v.b61;
    @(negedge clk);
    drive_req(v);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!walk) begin
      check("R2", "fast res_valid", 64'(res_valid), 64'd1);
      check("R2", "no walk", 64'(walk_req_valid), 64'd0);
      check(v.w ? (v.ev == 2'd0 ? "R3" : "R4") : "R9", "verdict", 64'(res_verdict), 64'(v.ev));
      check("R8", "reason", 64'(res_reason), 64'd0);
    end else begin
      check("R5", "walk start", 64'(walk_req_valid), 64'd1);
      check("R5", "walk gpa", 64'(walk_req_gpa), 64'(mk_gpa(v.idx)));
      check("R10", "ready low", 64'(req_ready), 64'd0);
      for (int k = 0; k < delay; k++) begin
        @(posedge clk);
        @(negedge clk);
        check("R5", "single pulse", 64'(walk_req_valid), 64'd0);
        check("R10", "still busy", 64'(req_ready), 64'd0);
      end
      walk_rsp_valid  = 1'b1;
      walk_rsp_status = v.st;
      walk_rsp_perm   = v.perm;
      @(posedge clk);
      @(negedge clk);
      walk_rsp_valid = 1'b0;
      check("R6", "walk res_valid", 64'(res_valid), 64'd1);
      check(v.st == 2'd0 ? "R6" : "R7", "verdict", 64'(res_verdict), 64'(v.ev));
      check("R7", "qual", res_qual, v.eq);
      check("R8", "reason", 64'(res_reason), (v.ev == 2'd2) ? 64'd66 : 64'd0);
      check("R10", "ready back", 64'(req_ready), 64'd1);
    end
    @(posedge clk);
    @(negedge clk);
    check("R11", "quiet after", {res_valid, res_verdict, res_qual, res_reason} == '0 ? 64'd1 : 64'd0, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", 64'(req_ready), 64'd1);
    check("R1", "res_valid in reset", 64'(res_valid), 64'd0);
    check("R1", "walk in reset", 64'(walk_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", 64'(req_ready), 64'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3);

    // R10: stray response while idle is dropped
    @(negedge clk);
    walk_rsp_valid = 1'b1;
    walk_rsp_perm  = '1;
    @(posedge clk);
    @(negedge clk);
    walk_rsp_valid = 1'b0;
    check("R10", "stray rsp", 64'(res_valid), 64'd0);

    // R10: request offered while busy is ignored
    drive_req(VECS[5]);
    @(posedge clk);
    @(negedge clk);
    check("R5", "walk for busy test", 64'(walk_req_valid), 64'd1);
    drive_req(VECS[0]);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "busy request dropped", 64'(res_valid), 64'd0);
    walk_rsp_valid  = 1'b1;
    walk_rsp_status = 2'd3;
    @(posedge clk);
    @(negedge clk);
    walk_rsp_valid = 1'b0;
    check("R7", "status 3 fault", 64'(res_verdict), 64'd2);
    check("R7", "status 3 qual", res_qual, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R10", "one result only", 64'(res_valid), 64'd0);

    // R2: back-to-back fast requests
    drive_req(VECS[1]);
    @(posedge clk);
    @(negedge clk);
    check("R4", "b2b first", 64'(res_verdict), 64'd1);
    drive_req(VECS[3]);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R3", "b2b second valid", 64'(res_valid), 64'd1);
    check("R3", "b2b second", 64'(res_verdict), 64'd0);

    // R1: reset during a pending lookup
    drive_req(VECS[9]);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R5", "walk before reset", 64'(walk_req_valid), 64'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "ready after abort", 64'(req_ready), 64'd1);
    check("R1", "walk cleared", 64'(walk_req_valid), 64'd0);
    rst_n = 1'b1;
    walk_rsp_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    walk_rsp_valid = 1'b0;
    check("R1", "late rsp dropped", 64'(res_valid), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule